// File: doc/BRIEF.md
# Pulse-Width Glitch Rejection Filter

This block cleans the single-bit data line coming out of an on-off keyed radio receiver before it reaches a frame decoder. That line is asynchronous to the system clock. It carries wanted runs whose lengths are whole multiples of a 100 us unit, with the shortest wanted run at 400 us. Between and on top of those runs the receiver also emits bursts of short spikes, typically 30 to 40 us long. A change of level on the line is accepted only when the new level persists for a programmable number of clock ticks. Shorter excursions are dropped completely. The filtered level comes out of a register, and each accepted change is also announced by a one-cycle rise or fall strobe. The downstream logic therefore sees only filtered edges, never raw activity.

The raw line first passes through a two-stage synchroniser. A four-state machine then tracks the filtered level and whether a candidate change is being qualified. The states are `ST_LO_IDLE` (output low, input agrees), `ST_LO_PEND` (output low, input high, being timed), `ST_HI_IDLE` (output high, input agrees) and `ST_HI_PEND` (output high, input low, being timed). The transitions are named as follows:
- *start*: IDLE to PEND, when the input first differs and the threshold is not yet met.
- *abort*: PEND to IDLE at the same level, when the input returns before qualifying.
- *accept*: IDLE or PEND to the opposite IDLE. This fires when the dwell count has reached the threshold while the input still differs, and it issues a strobe.

A dwell counter runs only while the synchronised input differs from the output. It is cleared on *abort* and on *accept*. Both edges of a pulse are delayed by the same amount, so an accepted pulse keeps its exact length. To reject 40 us spikes while passing 400 us runs, the threshold is set anywhere between those two lengths, expressed in clock ticks.

Top module: `glitch_reject_filter`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `level_o` is 0 and both `rise_o` and `fall_o` are 0.
- R2: With `min_ticks` = 0 the filter is transparent apart from its latency. A change of `raw_i` sampled at a clock edge appears on `level_o` three clock edges after that edge, counting the sampling edge as the first.
- R3: With `min_ticks` = T, a change of `raw_i` that persists appears on `level_o` exactly T+3 clock edges after the change is first sampled.
- R4: A pulse of `raw_i` that is sampled at T or fewer consecutive clock edges never changes `level_o` and produces no strobe. This holds for isolated spikes and for dense bursts of spikes, in both polarities.
- R5: If the synchronised input returns to the output level for even one sample, the qualification progress is discarded. A following pulse must qualify from zero.
- R6: An accepted pulse sampled at P consecutive edges (P ≥ T+1) appears on `level_o` as exactly P cycles at the new level.
- R7: `rise_o` is high for exactly one cycle, and only in the cycle in which `level_o` has just changed from 0 to 1.
- R8: `fall_o` is high for exactly one cycle, and only in the cycle in which `level_o` has just changed from 1 to 0.
- R9: `min_ticks` may change at run time. If it is lowered to a value at or below the dwell already accumulated, the pending change is accepted at the next clock edge.
- R10: Every change of `level_o` is accompanied by exactly one matching strobe. `rise_o` and `fall_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_i | input | 1 | Asynchronous raw receiver data |
| min_ticks | input | CNT_W | Number of extra qualifying samples required, in clock ticks |
| level_o | output | 1 | Filtered, registered data level |
| rise_o | output | 1 | One-cycle strobe on an accepted 0-to-1 change |
| fall_o | output | 1 | One-cycle strobe on an accepted 1-to-0 change |

## Verification
The in-RTL assertions check the following on every cycle:
- the synchroniser shifts correctly;
- strobes are mutually exclusive, last one cycle and agree in polarity with each level change;
- every accepted level matches the synchronised input that triggered it;
- an *abort* leaves the output unchanged.

The exact acceptance latency of T+3 edges, rejection at precisely T samples against acceptance at T+1, preserved pulse width, and counter restart after a single-sample return can only be shown by the bench's timed scenarios. The same holds for dense bursts in both polarities, run-time threshold lowering, and the real-scale 40 us versus 400 us case.

// File: rtl/glitch_pkg.sv
package glitch_pkg;

    // Filter state: the filtered level plus whether a change is being timed.
    typedef enum logic [1:0] {
        ST_LO_IDLE = 2'b00,
        ST_LO_PEND = 2'b01,
        ST_HI_IDLE = 2'b10,
        ST_HI_PEND = 2'b11
    } filt_state_t;

    // Filtered level carried by a state (upper bit of the encoding).
    function automatic logic state_level(input filt_state_t s);
        return s[1];
    endfunction

endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("gf_sync: STAGES must be at least 2");
        end
    endgenerate

    // Stage 0 samples the asynchronous line; later stages resolve metastability.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[LAST-1:0], d_i};
        end
    end

    assign q_o = chain[LAST];

    // Each output sample is the previous cycle's penultimate stage (R2).
    p_sync_shift_r2: assert property (@(posedge clk) disable iff (rst)
        q_o == $past(chain[LAST-1]))
        else $error("synchroniser did not shift");

endmodule

// File: rtl/gf_dwell_counter.sv
module gf_dwell_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             at_max;

    assign at_max = (cnt_q == CNT_MAX);

    // Counts samples for which the input differs; holds at the top value.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !at_max) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // The count never wraps from the top value back to zero without a clear (R9).
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt_q) == CNT_MAX && !$past(clr_i)) |-> cnt_q == CNT_MAX)
        else $error("dwell counter wrapped");

    // A clear and an increment are never requested together.
    p_clr_inc_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(clr_i && inc_i))
        else $error("dwell counter got clear and increment together");

endmodule

// File: rtl/gf_level_fsm.sv
module gf_level_fsm
    import glitch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    input  logic reached_i,
    output logic cnt_clr_o,
    output logic cnt_inc_o,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    filt_state_t state_q, state_d;
    logic        acc_rise, acc_fall;
    logic        rise_q, fall_q;

    // Next-state and counter control.
    always_comb begin
        state_d   = state_q;
        acc_rise  = 1'b0;
        acc_fall  = 1'b0;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        unique case (state_q)
            ST_LO_IDLE: begin
                if (sync_i) begin
                    if (reached_i) begin          // accept
                        state_d   = ST_HI_IDLE;
                        acc_rise  = 1'b1;
                        cnt_clr_o = 1'b1;
                    end else begin                // start
                        state_d   = ST_LO_PEND;
                        cnt_inc_o = 1'b1;
                    end
                end else begin
                    cnt_clr_o = 1'b1;
                end
            end
            ST_LO_PEND: begin
                if (!sync_i) begin                // abort
                    state_d   = ST_LO_IDLE;
                    cnt_clr_o = 1'b1;
                end else if (reached_i) begin     // accept
                    state_d   = ST_HI_IDLE;
                    acc_rise  = 1'b1;
                    cnt_clr_o = 1'b1;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            ST_HI_IDLE: begin
                if (!sync_i) begin
                    if (reached_i) begin          // accept
                        state_d   = ST_LO_IDLE;
                        acc_fall  = 1'b1;
                        cnt_clr_o = 1'b1;
                    end else begin                // start
                        state_d   = ST_HI_PEND;
                        cnt_inc_o = 1'b1;
                    end
                end else begin
                    cnt_clr_o = 1'b1;
                end
            end
            ST_HI_PEND: begin
                if (sync_i) begin                 // abort
                    state_d   = ST_HI_IDLE;
                    cnt_clr_o = 1'b1;
                end else if (reached_i) begin     // accept
                    state_d   = ST_LO_IDLE;
                    acc_fall  = 1'b1;
                    cnt_clr_o = 1'b1;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            default: begin
                state_d   = ST_LO_IDLE;
                cnt_clr_o = 1'b1;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LO_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: event strobes aligned with the new level.
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= acc_rise;
            fall_q <= acc_fall;
        end
    end

    assign level_o = state_level(state_q);
    assign rise_o  = rise_q;
    assign fall_o  = fall_q;

    // Strobes never together (R10).
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(rise_o && fall_o))
        else $error("rise and fall strobes together");

    // Rise strobe marks a fresh 0->1 change (R7).
    p_rise_edge_r7: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> (level_o && !$past(level_o)))
        else $error("rise strobe without rising level");

    // Fall strobe marks a fresh 1->0 change (R8).
    p_fall_edge_r8: assert property (@(posedge clk) disable iff (rst)
        fall_o |-> (!level_o && $past(level_o)))
        else $error("fall strobe without falling level");

    // Any level change carries a strobe (R10).
    p_change_strobed_r10: assert property (@(posedge clk) disable iff (rst)
        (level_o != $past(level_o)) |-> (rise_o || fall_o))
        else $error("level changed without strobe");

    // An accepted level equals the synchronised input that caused it (R3).
    p_accept_matches_r3: assert property (@(posedge clk) disable iff (rst)
        (level_o != $past(level_o)) |-> (level_o == $past(sync_i)))
        else $error("accepted level differs from input");

    // An abort leaves the output as it was (R5).
    p_abort_holds_r5: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_LO_PEND && !sync_i) || (state_q == ST_HI_PEND && sync_i))
        |=> $stable(level_o))
        else $error("abort changed the output");

    // Strobes last a single cycle (R7, R8).
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o)
        else $error("rise strobe longer than one cycle");

endmodule

// File: rtl/glitch_reject_filter.sv
module glitch_reject_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] min_ticks,
    output logic             level_o,
    output logic             rise_o,
    output logic             fall_o
);

    logic             sync_s;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] dwell;
    logic             reached;

    gf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_i),
        .q_o (sync_s)
    );

    gf_dwell_counter #(.CNT_W(CNT_W)) u_dwell (
        .clk   (clk),
        .rst   (rst),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (dwell)
    );

    // A comparison rather than equality lets a lowered threshold act at once.
    assign reached = (dwell >= min_ticks);

    gf_level_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sync_i    (sync_s),
        .reached_i (reached),
        .cnt_clr_o (cnt_clr),
        .cnt_inc_o (cnt_inc),
        .level_o   (level_o),
        .rise_o    (rise_o),
        .fall_o    (fall_o)
    );

    // Output is low on the first cycle after reset (R1).
    p_reset_low_r1: assert property (@(posedge clk)
        $fell(rst) |-> (!level_o && !rise_o && !fall_o))
        else $error("output not cleared by reset");

endmodule

// File: tb/glitch_reject_filter_tb.sv
module glitch_reject_filter_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             raw = 1'b0;
    logic [CNT_W-1:0] thr = '0;
    logic             level, rise, fall;

    int checks = 0;
    int errors = 0;
    int rise_cnt = 0, fall_cnt = 0, high_cnt = 0, bad_strobe = 0;
    logic prev_level = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    glitch_reject_filter #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .raw_i     (raw),
        .min_ticks (thr),
        .level_o   (level),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    // Monitor sampled on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (rise) rise_cnt++;
            if (fall) fall_cnt++;
            if (level) high_cnt++;
            if ((level && !prev_level && !(rise && !fall)) ||
                (!level && prev_level && !(fall && !rise)) ||
                (level == prev_level && (rise || fall)))
                bad_strobe++;
        end
        prev_level = level;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        rise_cnt = 0; fall_cnt = 0; high_cnt = 0;
    endtask

    task automatic t_reset();
        tick(3);
        chk(level == 0, "R1 level in reset", level, 0);
        chk(!rise && !fall, "R1 strobes in reset", rise + fall, 0);
        rst = 1'b0;
        tick(1);
        chk(level == 0 && !rise && !fall, "R1 after release", level + rise + fall, 0);
    endtask

    task automatic t_transparent();
        thr = 0; tick(2);
        raw = 1'b1;
        tick(2);
        chk(level == 0, "R2 before latency", level, 0);
        tick(1);
        chk(level == 1, "R2 level after 3 edges", level, 1);
        chk(rise == 1, "R7 rise strobe", rise, 1);
        tick(1);
        chk(rise == 0, "R7 rise one cycle", rise, 0);
        raw = 1'b0;
        tick(2);
        chk(level == 1, "R2 fall before latency", level, 1);
        tick(1);
        chk(level == 0 && fall == 1, "R8 fall strobe and level", {level, fall}, 1);
        tick(1);
        chk(fall == 0, "R8 fall one cycle", fall, 0);
    endtask

    task automatic t_latency();
        thr = 5; tick(3);
        raw = 1'b1;
        tick(7);
        chk(level == 0, "R3 not yet at T+2", level, 0);
        tick(1);
        chk(level == 1 && rise == 1, "R3 accepted at T+3", {level, rise}, 3);
        tick(4);
        raw = 1'b0;
        tick(7);
        chk(level == 1, "R3 fall not yet at T+2", level, 1);
        tick(1);
        chk(level == 0 && fall == 1, "R8 fall at T+3", {level, fall}, 1);
        tick(3);
    endtask

    task automatic t_boundary();
        thr = 6; tick(3); clear_mon();
        raw = 1'b1; tick(6); raw = 1'b0; tick(20);
        chk(level == 0 && rise_cnt == 0, "R4 pulse of T samples rejected", rise_cnt, 0);
        clear_mon();
        raw = 1'b1; tick(7); raw = 1'b0; tick(20);
        chk(rise_cnt == 1 && fall_cnt == 1, "R4 pulse of T+1 accepted", rise_cnt + fall_cnt, 2);
        chk(high_cnt == 7, "R6 width preserved T+1", high_cnt, 7);
        clear_mon();
        raw = 1'b1; tick(23); raw = 1'b0; tick(20);
        chk(high_cnt == 23, "R6 width preserved long", high_cnt, 23);
    endtask

    task automatic t_restart();
        thr = 6; tick(3); clear_mon();
        raw = 1'b1; tick(5); raw = 1'b0; tick(1); raw = 1'b1; tick(5); raw = 1'b0;
        tick(20);
        chk(level == 0 && rise_cnt == 0, "R5 progress discarded after one-sample return", rise_cnt, 0);
    endtask

    task automatic t_burst();
        thr = 8; tick(3); clear_mon();
        for (int i = 0; i < 30; i++) begin
            raw = 1'b1; tick(3); raw = 1'b0; tick(2);
        end
        tick(20);
        chk(level == 0 && rise_cnt == 0, "R4 high burst suppressed", rise_cnt, 0);
        raw = 1'b1; tick(20);
        chk(level == 1, "R3 settle high", level, 1);
        clear_mon();
        for (int i = 0; i < 30; i++) begin
            raw = 1'b0; tick(4); raw = 1'b1; tick(3);
        end
        tick(20);
        chk(level == 1 && fall_cnt == 0, "R4 low burst suppressed", fall_cnt, 0);
        raw = 1'b0; tick(20);
        chk(level == 0, "R4 settle low", level, 0);
    endtask

    task automatic t_runtime();
        thr = 50; tick(3);
        raw = 1'b1; tick(15);
        chk(level == 0, "R9 still pending", level, 0);
        thr = 3; tick(1);
        chk(level == 1 && rise == 1, "R9 lowered threshold accepts next edge", {level, rise}, 3);
        thr = 6; raw = 1'b0; tick(20);
    endtask

    task automatic t_scale();
        // 100 MHz clock: 40 us = 4000 ticks, 400 us = 40000, threshold 200 us.
        thr = 20000; tick(3); clear_mon();
        raw = 1'b1; tick(4000); raw = 1'b0; tick(20010);
        chk(level == 0 && rise_cnt == 0, "R4 40us spike rejected", rise_cnt, 0);
        clear_mon();
        raw = 1'b1; tick(40000); raw = 1'b0; tick(20010);
        chk(high_cnt == 40000, "R6 400us run preserved", high_cnt, 40000);
        chk(rise_cnt == 1 && fall_cnt == 1, "R7 R8 one strobe each", rise_cnt + fall_cnt, 2);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_latency();
        t_boundary();
        t_restart();
        t_burst();
        t_runtime();
        t_scale();
        chk(bad_strobe == 0, "R10 every change strobed once", bad_strobe, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule